// File: doc/BRIEF.md
# PCI Slot Interrupt Merger

This block merges the level interrupt lines of three PCI device slots and the PCI controller core into one chained interrupt towards the CPU. Each clock it samples the lines into a status register. An enable register decides which sources may reach the CPU. Software can load the enable register whole, or set and clear single bits through dedicated mask and unmask strobes.

The sources sit on a sparse five-bit map: slot 0 at bit 0, slot 1 at bit 1, slot 2 at bit 2 and the core at bit 4. Bit 3 is reserved. It always reads zero, and writes to it are dropped. The block outputs the pending vector and the index of the most urgent pending source, using fixed priority slot 0, slot 1, slot 2, then core. When the handler services the summary line while no enabled source is pending, the block raises a spurious flag.

Top module: `pci_irq_merge`

## Requirements
- R1: Outside a status write, the status register loads {core_irq, 0, dev_irq[2:0]} on every clock edge. It visibly follows the levels with one cycle of latency. Status bit 3 is always zero.
- R2: An asynchronous reset clears status, enable and spurious. A write with reg_addr=1 loads enable from reg_wdata, with bit 3 forced to zero.
- R3: mask_req with a valid op_idx (0, 1, 2 or 4) clears enable bit op_idx on the next edge. All other enable bits keep their value.
- R4: unmask_req with a valid op_idx sets enable bit op_idx and keeps the others. When mask_req and unmask_req arrive together, unmask wins.
- R5: mask_req or unmask_req with op_idx 3, 5, 6 or 7 leaves the enable register unchanged.
- R6: pend_vec equals status AND enable. cpu_irq is high exactly when pend_vec is non-zero.
- R7: top_idx reports the lowest set bit of pend_vec in the order 0, 1, 2, 4. top_valid equals cpu_irq. With nothing pending, top_idx is 0.
- R8: svc_req in a cycle where pend_vec is zero raises spurious for exactly the next cycle. svc_req with a source pending leaves spurious low.
- R9: reg_rdata is combinational from reg_addr: 0 gives status, 1 gives enable, 2 gives pend_vec and 3 gives zero.
- R10: A write with reg_addr=0 loads status from reg_wdata (bit 3 forced to zero) for one cycle. After that, status samples the lines again.
- R11: A register write to enable in the same cycle as mask_req or unmask_req takes precedence over the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 3 | Level interrupt lines of slots 0..2 |
| core_irq | input | 1 | Level interrupt of the controller core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 pending, 3 none |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data |
| mask_req | input | 1 | Clear enable bit op_idx |
| unmask_req | input | 1 | Set enable bit op_idx |
| op_idx | input | 3 | Source index for mask/unmask |
| svc_req | input | 1 | Handler is servicing the summary interrupt |
| pend_vec | output | 5 | Status AND enable |
| cpu_irq | output | 1 | Chained summary interrupt |
| top_valid | output | 1 | A source is pending |
| top_idx | output | 3 | Index of highest-priority pending source |
| spurious | output | 1 | Service request with nothing pending |

## Verification
A corrupted enable bit shows at once on pend_vec and cpu_irq while its source line is high. Even with the line low, it shows on an enable read at reg_addr=1 in that same cycle. A wrong status bit appears one edge after the line changes. The bench therefore drives the lines both with and without enables, and reads every address on every vector. A priority fault shows on top_idx only when two or more sources are pending together, so patterns with several sources pending are driven on purpose. A spurious-flag fault shows in the cycle right after a service request.

// File: rtl/pci_irq_merge.sv
module pci_irq_merge #(
  parameter int NDEV = 3,
  parameter int NSRC = 5,
  parameter int IW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_irq,
  input  logic            core_irq,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  input  logic            mask_req,
  input  logic            unmask_req,
  input  logic [IW-1:0]   op_idx,
  input  logic            svc_req,
  output logic [NSRC-1:0] pend_vec,
  output logic            cpu_irq,
  output logic            top_valid,
  output logic [IW-1:0]   top_idx,
  output logic            spurious
);
  localparam int CORE_BIT = NSRC - 1;
  localparam logic [NSRC-1:0] LIVE = {1'b1, {(NSRC-1-NDEV){1'b0}}, {NDEV{1'b1}}};

  logic [NSRC-1:0] status_q, en_q, en_nxt, lines;
  logic            op_ok;

  assign lines = {core_irq, {(NSRC-1-NDEV){1'b0}}, dev_irq};
  assign op_ok = (int'(op_idx) < NSRC) && LIVE[op_idx[$clog2(NSRC)-1:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         status_q <= '0;
    else if (reg_wr && reg_addr == 2'd0) status_q <= reg_wdata & LIVE;
    else                                status_q <= lines;

  always_comb begin
    en_nxt = en_q;
    if (reg_wr && reg_addr == 2'd1)
      en_nxt = reg_wdata & LIVE;
    else if (op_ok)
      for (int i = 0; i < NSRC; i++)
        if (i == int'(op_idx)) begin
          if (mask_req)   en_nxt[i] = 1'b0;
          if (unmask_req) en_nxt[i] = 1'b1;
        end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else        en_q <= en_nxt;

  assign pend_vec = status_q & en_q;
  assign cpu_irq  = |pend_vec;

  always_comb begin
    top_valid = 1'b0;
    top_idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend_vec[i]) begin
        top_valid = 1'b1;
        top_idx   = IW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) spurious <= 1'b0;
    else        spurious <= svc_req && !cpu_irq;

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = status_q;
      2'd1:    reg_rdata = en_q;
      2'd2:    reg_rdata = pend_vec;
      default: reg_rdata = '0;
    endcase

  logic unused_core;
  assign unused_core = lines[CORE_BIT] & 1'b0;
endmodule

module pci_irq_merge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       mask_req,
  input logic       unmask_req,
  input logic [2:0] op_idx,
  input logic       svc_req,
  input logic [4:0] status_q,
  input logic [4:0] en_q,
  input logic       cpu_irq,
  input logic       top_valid,
  input logic [2:0] top_idx,
  input logic       spurious
);
  // R1
  reserved_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[3] && !en_q[3]);
  // R3
  mask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_req && !unmask_req && !(reg_wr && reg_addr == 2'd1) &&
     (op_idx == 3'd0 || op_idx == 3'd1 || op_idx == 3'd2 || op_idx == 3'd4))
    |=> !en_q[$past(op_idx)]);
  // R5
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_req || unmask_req) && op_idx == 3'd3 && !reg_wr) |=> $stable(en_q));
  // R7
  top_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_valid == cpu_irq) && top_idx != 3'd3 && top_idx <= 3'd4);
  // R8
  spurious_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> ($past(svc_req) && !$past(cpu_irq)));
endmodule

bind pci_irq_merge pci_irq_merge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .mask_req(mask_req), .unmask_req(unmask_req), .op_idx(op_idx),
  .svc_req(svc_req), .status_q(status_q), .en_q(en_q), .cpu_irq(cpu_irq),
  .top_valid(top_valid), .top_idx(top_idx), .spurious(spurious)
);

// File: tb/sim_pci_irq_merge.sv
`timescale 1ns/1ps
module sim_pci_irq_merge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] dev_irq = '0;
  logic core_irq = 1'b0, reg_wr = 1'b0, mask_req = 1'b0, unmask_req = 1'b0, svc_req = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [4:0] reg_wdata = '0;
  logic [2:0] op_idx = '0;
  logic [4:0] reg_rdata, pend_vec;
  logic cpu_irq, top_valid, spurious;
  logic [2:0] top_idx;

  int vectors = 0, fails = 0;
  logic [4:0] m_st = '0, m_en = '0;
  logic m_sp = 1'b0;

  always #4 clk = ~clk;

  pci_irq_merge u0 (.*);

  // Reference model: behavioural, integer based
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_st = 0; m_en = 0; m_sp = 0; end
    else begin
      logic [4:0] p;
      int k;
      p = m_st & m_en;
      m_sp = svc_req && (p == 0);
      k = op_idx;
      if (reg_wr && reg_addr == 1) m_en = reg_wdata & 5'b10111;
      else if (k == 0 || k == 1 || k == 2 || k == 4) begin
        if (mask_req)   m_en = m_en & ~(5'd1 << k);
        if (unmask_req) m_en = m_en | (5'd1 << k);
      end
      if (reg_wr && reg_addr == 0) m_st = reg_wdata & 5'b10111;
      else m_st = {core_irq, 1'b0, dev_irq};
    end
  end

  task automatic cmp(input string r, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic check();
    logic [4:0] p, rd;
    int ti;
    p = m_st & m_en;
    ti = p[0] ? 0 : p[1] ? 1 : p[2] ? 2 : p[4] ? 4 : 0;
    rd = reg_addr == 0 ? m_st : reg_addr == 1 ? m_en : reg_addr == 2 ? p : 5'd0;
    vectors++;
    cmp("R6 pend_vec", pend_vec, p);
    cmp("R6 cpu_irq", cpu_irq, p != 0);
    cmp("R7 top_valid", top_valid, p != 0);
    cmp("R7 top_idx", top_idx, ti);
    cmp("R8 spurious", spurious, m_sp);
    cmp("R9 reg_rdata", reg_rdata, rd);
  endtask

  task automatic step(input logic [2:0] d, input logic c, input logic w, input logic [1:0] a,
                      input logic [4:0] wd, input logic mk, input logic um,
                      input logic [2:0] ix, input logic sv);
    @(negedge clk);
    dev_irq = d; core_irq = c; reg_wr = w; reg_addr = a; reg_wdata = wd;
    mask_req = mk; unmask_req = um; op_idx = ix; svc_req = sv;
    #1 check();
  endtask

  task automatic idle(input logic [2:0] d, input logic c, input logic [1:0] a);
    step(d, c, 0, a, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R2: reset state
    idle(3'b111, 1, 0); idle(3'b111, 1, 1);
    @(negedge clk) rst_n = 1'b1;
    // R1: status follows lines, nothing enabled
    idle(3'b101, 1, 0); idle(3'b101, 1, 0); idle(3'b010, 0, 0); idle(3'b010, 0, 2);
    // R8: service with nothing pending, then quiet
    step(3'b010, 0, 0, 0, 0, 0, 0, 0, 1); idle(3'b010, 0, 0); idle(3'b010, 0, 0);
    // R4: unmask 4, 2, 1
    step(3'b111, 1, 0, 1, 0, 0, 1, 4, 0);
    step(3'b111, 1, 0, 1, 0, 0, 1, 2, 0);
    step(3'b111, 1, 0, 1, 0, 0, 1, 1, 0);
    idle(3'b111, 1, 2);
    // R7: priority sweep
    idle(3'b110, 1, 2); idle(3'b100, 1, 2); idle(3'b000, 1, 2); idle(3'b000, 0, 2); idle(3'b000, 0, 2);
    // R5: invalid indices do nothing
    step(3'b111, 1, 0, 1, 0, 1, 0, 3, 0);
    step(3'b111, 1, 0, 1, 0, 0, 1, 3, 0);
    step(3'b111, 1, 0, 1, 0, 1, 0, 6, 0);
    step(3'b111, 1, 0, 1, 0, 0, 1, 7, 0);
    idle(3'b111, 1, 1);
    // R3: mask 1 keeps others; R8 service with pending
    step(3'b111, 1, 0, 1, 0, 1, 0, 1, 1); idle(3'b111, 1, 1); idle(3'b111, 1, 2);
    // R4: both strobes, unmask wins
    step(3'b111, 1, 0, 1, 0, 1, 1, 0, 0); idle(3'b111, 1, 2);
    // R2: full write, bit 3 dropped
    step(3'b000, 0, 1, 1, 5'b11111, 0, 0, 0, 0); idle(3'b000, 0, 1);
    // R10: status write for one cycle
    step(3'b000, 0, 1, 0, 5'b11111, 0, 0, 0, 0); idle(3'b000, 0, 0); idle(3'b000, 0, 0);
    // R11: write beats mask
    step(3'b111, 1, 1, 1, 5'b00001, 1, 0, 0, 0); idle(3'b111, 1, 1);
    step(3'b111, 1, 1, 1, 5'b00000, 0, 1, 4, 0); idle(3'b111, 1, 1);
    // R9: address 3 reads zero
    idle(3'b111, 1, 3);
    // mixed random traffic covering all requirements
    for (int i = 0; i < 600; i++)
      step(3'($urandom), 1'($urandom), ($urandom % 5) == 0, 2'($urandom), 5'($urandom),
           ($urandom % 4) == 0, ($urandom % 4) == 0, 3'($urandom), ($urandom % 3) == 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule